// File: doc/BRIEF.md
# Interrupt Cause Group with Selectable Clear Mode

This block collects one group of up to 32 interrupt causes. Single-cycle event pulses from the datapath latch into a cause register. A mask register gates which latched causes reach the output. The block drives a pending vector, which is the cause ANDed with the inverted mask, and the OR of that vector. The OR feeds an upstream interrupt aggregator.

The host reaches the block through a minimal address, write-strobe and read-strobe port. Five addresses are decoded:

| Address | Function |
|---|---|
| 0 | Cause access |
| 1 | Mask set |
| 2 | Mask clear |
| 3 | Clear-mode configuration |
| 4 | Mask readback |

The mask is never written directly. Set and clear go through separate addresses, so bits owned by different software agents are not lost in a read-modify-write race. At run time the host chooses whether a cause read empties the register (clear-on-read) or whether causes are acknowledged by writing ones (write-1-to-clear).

A typical transmit instance uses bits 0 to 24 for per-ring completions and one further bit for overall transmit done. A receive instance uses one bit for receive done and another for buffer near overflow. The block itself treats every bit alike.

Top module: `irq_cause_group`

## Requirements
- R1: After reset the cause register is zero, every mask bit is one, the clear mode is write-1-to-clear, pend_o is zero and irq_o is low.
- R2: A one on evt_i bit n sets cause bit n at the next clock edge. The bit stays set until cleared, and it latches whether or not mask bit n is set. pend_o equals cause AND NOT mask, and irq_o is the OR of pend_o.
- R3: A write to address 1 sets the mask bits that are one in the write data (disabling those causes). A write to address 2 clears the mask bits that are one in the write data (enabling them). Other mask bits are unchanged.
- R4: A read returns its data on host_rdata_o in the cycle after host_rd_i. A read of address 4 returns the current mask and changes no state.
- R5: A write of all ones to address 3 selects clear-on-read. A write of any other value selects write-1-to-clear. A read of address 3 returns all ones in clear-on-read and zero in write-1-to-clear.
- R6: In write-1-to-clear mode, a read of address 0 returns the cause without changing it. A write to address 0 clears the cause bits that are one in the write data.
- R7: In clear-on-read mode, a read of address 0 returns the cause and clears it at the same edge. A write to address 0 has no effect.
- R8: When an event and a clear (by write or by read) hit the same cause bit in the same cycle, the bit is set after the edge.
- R9: Clearing the mask bit of an already latched cause raises the matching pend_o bit and irq_o in the cycle after the mask-clear write.
- R10: Reads of addresses 5 to 7 return zero. Writes to them change neither the mask nor the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | WIDTH | Event pulses from the datapath, one per cause bit |
| host_addr_i | input | 3 | Host register address |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | WIDTH | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | WIDTH | Registered read data, valid the cycle after host_rd_i |
| pend_o | output | WIDTH | Latched and enabled causes |
| irq_o | output | 1 | OR of pend_o, to the aggregator |

## Verification
The bench builds the block with its default width of 32. At that width, all-ones versus other-value mode writes are meaningful, and high bits such as the overall transmit-done position next to a 25-bit ring field can be exercised alongside low bits. Because the width is the full host data width, the all-ones mask after reset and the all-ones mode pattern are the exact values a driver writes. Event pulses are placed on the same edge as host clears, in both clear modes, so the event-wins priority and the read-returns-old-value timing are both reached.

// File: rtl/irq_grp_pkg.sv
`timescale 1ns/1ps
package irq_grp_pkg;

    localparam int unsigned GRP_ADDR_W = 3;

    typedef enum logic [GRP_ADDR_W-1:0] {
        SEL_CAUSE    = 3'd0,
        SEL_MASK_SET = 3'd1,
        SEL_MASK_CLR = 3'd2,
        SEL_MODE     = 3'd3,
        SEL_MASK_VAL = 3'd4
    } grp_sel_e;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_CAUSE = 2'd1,
        RD_MODE  = 2'd2,
        RD_MASK  = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic    cause_wr;
        logic    cause_rd;
        logic    mset_wr;
        logic    mclr_wr;
        logic    mode_wr;
        logic    rd_any;
        rd_src_e rd_src;
    } host_stb_t;

endpackage

// File: rtl/irq_host_decode.sv
`timescale 1ns/1ps
module irq_host_decode
    import irq_grp_pkg::*;
(
    input  logic [GRP_ADDR_W-1:0] addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    output host_stb_t             stb_o
);

    always_comb begin
        stb_o        = '0;
        stb_o.rd_any = rd_i;
        stb_o.rd_src = RD_NONE;
        unique case (addr_i)
            SEL_CAUSE: begin
                stb_o.cause_wr = wr_i;
                stb_o.cause_rd = rd_i;
                stb_o.rd_src   = RD_CAUSE;
            end
            SEL_MASK_SET: stb_o.mset_wr = wr_i;
            SEL_MASK_CLR: stb_o.mclr_wr = wr_i;
            SEL_MODE: begin
                stb_o.mode_wr = wr_i;
                stb_o.rd_src  = RD_MODE;
            end
            SEL_MASK_VAL: stb_o.rd_src = RD_MASK;
            default:      stb_o.rd_src = RD_NONE;
        endcase
    end

endmodule

// File: rtl/irq_cause_bank.sv
`timescale 1ns/1ps
module irq_cause_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             cor_i,
    input  logic             wr_stb_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_stb_i,
    output logic [WIDTH-1:0] cause_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cause;
    } cause_st_t;

    cause_st_t        st_d, st_q;
    logic [WIDTH-1:0] clr_vec;

    // Clear source depends on mode; the event term is ORed last so it wins.
    always_comb begin
        clr_vec = '0;
        if (cor_i && rd_stb_i) begin
            clr_vec = st_q.cause;
        end else if (!cor_i && wr_stb_i) begin
            clr_vec = wr_data_i;
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            st_d.cause[b] = (st_q.cause[b] & ~clr_vec[b]) | evt_i[b];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;

endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             set_stb_i,
    input  logic             clr_stb_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] mask_o
);

    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_stb_i) begin
            st_d.mask = st_q.mask | data_i;
        end else if (clr_stb_i) begin
            st_d.mask = st_q.mask & ~data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_cause_group.sv
`timescale 1ns/1ps
module irq_cause_group
    import irq_grp_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [WIDTH-1:0]      evt_i,
    input  logic [GRP_ADDR_W-1:0] host_addr_i,
    input  logic                  host_wr_i,
    input  logic [WIDTH-1:0]      host_wdata_i,
    input  logic                  host_rd_i,
    output logic [WIDTH-1:0]      host_rdata_o,
    output logic [WIDTH-1:0]      pend_o,
    output logic                  irq_o
);

    typedef struct packed {
        logic             cor;
        logic [WIDTH-1:0] rdata;
    } top_st_t;

    host_stb_t        stb;
    top_st_t          st_d, st_q;
    logic [WIDTH-1:0] cause_w;
    logic [WIDTH-1:0] mask_w;
    logic             cor_w;

    irq_host_decode u_dec (
        .addr_i (host_addr_i),
        .wr_i   (host_wr_i),
        .rd_i   (host_rd_i),
        .stb_o  (stb)
    );

    irq_cause_bank #(.WIDTH(WIDTH)) u_cause (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_i),
        .cor_i     (st_q.cor),
        .wr_stb_i  (stb.cause_wr),
        .wr_data_i (host_wdata_i),
        .rd_stb_i  (stb.cause_rd),
        .cause_o   (cause_w)
    );

    irq_mask_bank #(.WIDTH(WIDTH)) u_mask (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_stb_i (stb.mset_wr),
        .clr_stb_i (stb.mclr_wr),
        .data_i    (host_wdata_i),
        .mask_o    (mask_w)
    );

    always_comb begin
        st_d = st_q;
        if (stb.mode_wr) begin
            st_d.cor = (host_wdata_i == {WIDTH{1'b1}});
        end
        if (stb.rd_any) begin
            unique case (stb.rd_src)
                RD_CAUSE: st_d.rdata = cause_w;
                RD_MODE:  st_d.rdata = {WIDTH{st_q.cor}};
                RD_MASK:  st_d.rdata = mask_w;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cor_w        = st_q.cor;
    assign host_rdata_o = st_q.rdata;
    assign pend_o       = cause_w & ~mask_w;
    assign irq_o        = |pend_o;

endmodule

// File: rtl/irq_cause_group_chk.sv
`timescale 1ns/1ps
module irq_cause_group_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] evt_i,
    input logic [2:0]       addr_i,
    input logic             wr_i,
    input logic [WIDTH-1:0] wdata_i,
    input logic             rd_i,
    input logic [WIDTH-1:0] rdata_i,
    input logic [WIDTH-1:0] cause_i,
    input logic [WIDTH-1:0] mask_i,
    input logic             cor_i
);

    AST_EVT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((cause_i & $past(evt_i)) == $past(evt_i))); // R8

    AST_MASK_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd1) |=> ((mask_i & $past(wdata_i)) == $past(wdata_i))); // R3

    AST_MASK_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd2) |=> ((mask_i & $past(wdata_i)) == '0)); // R3

    AST_MASK_READ_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !wr_i && addr_i == 3'd4) |=> ($stable(mask_i) && rdata_i == $past(mask_i))); // R4

    AST_W1C_READ_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cor_i && rd_i && !wr_i && addr_i == 3'd0)
        |=> ((cause_i & $past(cause_i)) == $past(cause_i))); // R6

    AST_COR_READ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cor_i && rd_i && addr_i == 3'd0) |=> ((cause_i & ~$past(evt_i)) == '0)); // R7

    AST_HIGH_ADDR_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !rd_i && addr_i > 3'd4) |=> $stable(mask_i)); // R10

endmodule

bind irq_cause_group irq_cause_group_chk #(.WIDTH(WIDTH)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .addr_i  (host_addr_i),
    .wr_i    (host_wr_i),
    .wdata_i (host_wdata_i),
    .rd_i    (host_rd_i),
    .rdata_i (host_rdata_o),
    .cause_i (cause_w),
    .mask_i  (mask_w),
    .cor_i   (cor_w)
);

// File: tb/irq_cause_group_tb_top.sv
`timescale 1ns/1ps
module irq_cause_group_tb_top;

    localparam int unsigned W = 32;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt = '0;
    logic [2:0]   addr = '0;
    logic         wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rd = 1'b0;
    logic [W-1:0] rdata;
    logic [W-1:0] pend;
    logic         irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_cause_group #(.WIDTH(W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .evt_i        (evt),
        .host_addr_i  (addr),
        .host_wr_i    (wr),
        .host_wdata_i (wdata),
        .host_rd_i    (rd),
        .host_rdata_o (rdata),
        .pend_o       (pend),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All drives happen at the falling edge; results are sampled at the next falling edge.
    task automatic do_wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] e = '0);
        addr = a; wdata = d; wr = 1'b1; evt = e;
        @(negedge clk);
        wr = 1'b0; evt = '0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [W-1:0] d, input logic [W-1:0] e = '0);
        addr = a; rd = 1'b1; evt = e;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        d = rdata;
    endtask

    task automatic pulse(input logic [W-1:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check("R1 pend", pend, '0);
        check("R1 irq", {31'd0, irq}, '0);
        do_rd(3'd4, v); check("R1 mask", v, ONES);
        do_rd(3'd3, v); check("R1 mode", v, '0);
        do_rd(3'd0, v); check("R1 cause", v, '0);
    endtask

    task automatic t_latch_masked();
        logic [W-1:0] v;
        pulse(32'h0200_0005);
        check("R2 masked irq", {31'd0, irq}, '0);
        do_rd(3'd0, v); check("R2 latched", v, 32'h0200_0005);
        do_rd(3'd0, v); check("R6 read keeps", v, 32'h0200_0005);
    endtask

    task automatic t_unmask();
        logic [W-1:0] v;
        do_wr(3'd2, 32'h0200_0001);
        check("R9 pend", pend, 32'h0200_0001);
        check("R9 irq", {31'd0, irq}, 32'd1);
        do_rd(3'd4, v); check("R3 mask clr", v, ~32'h0200_0001);
        do_wr(3'd1, 32'h0000_0001);
        check("R3 mask set pend", pend, 32'h0200_0000);
        do_wr(3'd1, ONES);
        check("R3 all masked irq", {31'd0, irq}, '0);
    endtask

    task automatic t_w1c();
        logic [W-1:0] v;
        do_wr(3'd0, 32'h0000_0004);
        do_rd(3'd0, v); check("R6 w1c", v, 32'h0200_0001);
        do_wr(3'd0, 32'h0200_0001);
        do_rd(3'd0, v); check("R6 w1c all", v, '0);
    endtask

    task automatic t_race_w1c();
        logic [W-1:0] v;
        pulse(32'h0000_0008);
        do_wr(3'd0, 32'h0000_0008, 32'h0000_0008);
        do_rd(3'd0, v); check("R8 w1c race", v, 32'h0000_0008);
        do_wr(3'd0, 32'h0000_0008);
    endtask

    task automatic t_cor();
        logic [W-1:0] v;
        do_wr(3'd3, ONES);
        do_rd(3'd3, v); check("R5 cor mode", v, ONES);
        pulse(32'h0000_0030);
        do_rd(3'd0, v); check("R7 cor value", v, 32'h0000_0030);
        do_rd(3'd0, v); check("R7 cor cleared", v, '0);
        pulse(32'h0000_0002);
        do_wr(3'd0, 32'h0000_0002);
        do_rd(3'd0, v); check("R7 write ignored", v, 32'h0000_0002);
        do_rd(3'd0, v, 32'h0000_0040); check("R8 cor race old", v, '0);
        do_rd(3'd0, v); check("R8 cor race kept", v, 32'h0000_0040);
    endtask

    task automatic t_mode_other();
        logic [W-1:0] v;
        do_wr(3'd3, 32'h0000_0001);
        do_rd(3'd3, v); check("R5 other value", v, '0);
        pulse(32'h0000_0100);
        do_rd(3'd0, v);
        do_rd(3'd0, v); check("R5 back to w1c", v, 32'h0000_0100);
        do_wr(3'd0, 32'h0000_0100);
    endtask

    task automatic t_unmapped();
        logic [W-1:0] v;
        pulse(32'h0000_0800);
        do_wr(3'd5, '0);
        do_wr(3'd6, ONES);
        do_wr(3'd7, 32'h0000_0800);
        do_rd(3'd4, v); check("R10 mask kept", v, ONES);
        do_rd(3'd0, v); check("R10 cause kept", v, 32'h0000_0800);
        for (int a = 5; a < 8; a++) begin
            do_rd(a[2:0], v); check("R10 read zero", v, '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_masked();
        t_unmask();
        t_w1c();
        t_race_w1c();
        t_cor();
        t_mode_other();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule